// File: doc/BRIEF.md
# I2C Register-File Slave with Pointer Auto-Increment

This block lets an I2C bus master read and write a 128-entry byte register file. SCL and SDA are brought into a fast system clock domain through two-flop synchronizers. START, repeated START and STOP are recognised from the synchronized lines. After a START the slave shifts in an address byte and compares its upper seven bits with the `DEV_ADDR` parameter. It acknowledges only on a match. In a write transfer the first data byte is a register pointer byte. Its low seven bits load the register pointer and its top bit turns on auto-increment. Every later byte is stored at the pointer.

A read is done by first writing the pointer byte and then issuing a repeated START with the read direction bit. The slave then returns register bytes MSB first. Before each byte it holds SCL low for a fixed number of system cycles while the byte is fetched. Reading continues while the master acknowledges. After the master sends a not-acknowledge, the slave lets go of SDA. User logic has its own port to the same array for reads and writes. Both pad drivers are open-drain and appear as output enables: when an enable is high, the pad pulls the line low.

The system clock must run at least eight times the SCL rate.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset both output enables are low, the bus is treated as idle, and every register reads 0x00 on the user port.
- R2: The address byte is taken MSB first. Bits 7..1 are the device address and bit 0 is the direction (1 = read). The slave pulls SDA low in the ninth clock only if bits 7..1 equal `DEV_ADDR`. Otherwise SDA stays released and the rest of the transfer, up to the next START, changes no register.
- R3: In a write transfer, the byte after the acknowledged address is the pointer byte. Bits 6..0 become the register pointer and bit 7 turns auto-increment on (1) or off (0).
- R4: Every acknowledge the slave gives pulls SDA low before SCL rises and keeps it low through the whole high phase of the ninth clock. SDA stays stable while SCL is high.
- R5: Each write data byte, received MSB first and acknowledged, is stored in the register at the pointer.
- R6: After a repeated START with the read bit set, the slave drives the register at the pointer MSB first, one byte per eight clocks.
- R7: With auto-increment on, the pointer advances by one after each data byte written or read, wrapping from 127 to 0. With it off, the pointer stays fixed.
- R8: Before each read byte, the slave holds SCL low for `STRETCH_CYC` system cycles. It never stretches during write transfers.
- R9: A not-acknowledge from the master after a read byte makes the slave release SDA until the next START or STOP. A STOP or START at any point returns the slave to waiting for an address and releases both lines.
- R10: The user port reads the register at `usr_addr_i` combinationally. A user write takes effect at the next clock edge and is visible to the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge or data 0) |
| usr_addr_i | input | 7 | User port register index |
| usr_we_i | input | 1 | User port write strobe |
| usr_wdata_i | input | 8 | User port write data |
| usr_rdata_o | output | 8 | User port read data |

## Verification
The hardest case to reach is the pointer wrap in the middle of a long auto-increment burst combined with clock stretching on every read byte. The bench reaches it with a single write burst of 128 bytes starting at index 120, followed by a single read burst of 128 bytes starting at index 100. Both bursts cross 127 to 0, and every register is covered by arithmetic patterns. A STOP arriving partway through a data byte is produced by cutting a byte off after four bits. The address comparison is swept over all 127 non-matching addresses.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_RWAIT
    } slv_state_e;
endpackage

// File: rtl/i2c_rf_sense.sv
module i2c_rf_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINE = 2;   // index 1 = SCL, index 0 = SDA

    typedef struct packed {
        logic [NLINE-1:0] meta;
        logic [NLINE-1:0] sync;
        logic [NLINE-1:0] prev;
    } sense_t;

    sense_t s_d, s_q;
    logic [NLINE-1:0] raw;

    assign raw = {scl_i, sda_i};

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: '1, sync: '1, prev: '1};
        else        s_q <= s_d;
    end

    logic [NLINE-1:0] rise_v, fall_v;

    for (genvar g = 0; g < NLINE; g++) begin : g_edge
        assign rise_v[g] =  s_q.sync[g] & ~s_q.prev[g];
        assign fall_v[g] = ~s_q.sync[g] &  s_q.prev[g];
    end

    logic scl_hi2;
    assign scl_hi2  = s_q.sync[1] & s_q.prev[1];

    assign scl_s    = s_q.sync[1];
    assign sda_s    = s_q.sync[0];
    assign scl_rise = rise_v[1];
    assign scl_fall = fall_v[1];
    assign start_ev = scl_hi2 & fall_v[0];
    assign stop_ev  = scl_hi2 & rise_v[0];
endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_waddr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [AW-1:0] bus_raddr,
    output logic [DW-1:0] bus_rdata,
    input  logic [AW-1:0] usr_addr,
    input  logic          usr_we,
    input  logic [DW-1:0] usr_wdata,
    output logic [DW-1:0] usr_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    // Bus write is applied last, so it wins a same-cycle collision.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (usr_we && usr_addr == AW'(g)) mem_d[g] = usr_wdata;
            if (bus_we && bus_waddr == AW'(g)) mem_d[g] = bus_wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign bus_rdata = mem_q[bus_raddr];
    assign usr_rdata = mem_q[usr_addr];
endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         AW          = 7,
    parameter int         STRETCH_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic [AW-1:0]     ptr,
    output logic              auto_inc,
    output logic              bus_we,
    output logic [AW-1:0]     bus_waddr,
    output logic [BYTE_W-1:0] bus_wdata
);
    localparam int SCW = $clog2(STRETCH_CYC + 2);
    localparam logic [3:0] BITS_IN = 4'(BYTE_W);
    localparam logic [3:0] LAST_OUT = 4'(BYTE_W - 1);

    typedef struct packed {
        slv_state_e        state;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [AW-1:0]     ptr;
        logic              inc;
        logic              rnw;
        logic              mnak;
        logic              sda_oe;
        logic              scl_oe;
        logic [SCW-1:0]    scnt;
        logic              we;
        logic [AW-1:0]     waddr;
        logic [BYTE_W-1:0] wdata;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  rx_state;

    assign rx_state = (c_q.state == ST_ADDR) || (c_q.state == ST_PTR) ||
                      (c_q.state == ST_WDATA);

    always_comb begin
        c_d    = c_q;
        c_d.we = 1'b0;

        // clock-stretch countdown
        if (c_q.scnt != '0) begin
            c_d.scnt   = c_q.scnt - 1'b1;
            c_d.scl_oe = (c_q.scnt != SCW'(1));
        end

        // shift in on SCL rise while receiving
        if (rx_state && scl_rise) begin
            c_d.shreg  = {c_q.shreg[BYTE_W-2:0], sda_s};
            c_d.bitcnt = c_q.bitcnt + 1'b1;
        end

        unique case (c_q.state)
            ST_ADDR: begin
                if (scl_fall && c_q.bitcnt == BITS_IN) begin
                    c_d.bitcnt = '0;
                    if (c_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                        c_d.sda_oe = 1'b1;
                        c_d.rnw    = c_q.shreg[0];
                        c_d.state  = ST_ADDR_ACK;
                    end else begin
                        c_d.state  = ST_IDLE;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    c_d.sda_oe = 1'b0;
                    if (c_q.rnw) begin
                        c_d.shreg  = rd_byte;
                        c_d.sda_oe = ~rd_byte[BYTE_W-1];
                        c_d.bitcnt = '0;
                        c_d.state  = ST_RDATA;
                        if (STRETCH_CYC > 0) begin
                            c_d.scnt   = SCW'(STRETCH_CYC);
                            c_d.scl_oe = 1'b1;
                        end
                    end else begin
                        c_d.state = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                if (scl_fall && c_q.bitcnt == BITS_IN) begin
                    c_d.bitcnt = '0;
                    c_d.ptr    = c_q.shreg[AW-1:0];
                    c_d.inc    = c_q.shreg[BYTE_W-1];
                    c_d.sda_oe = 1'b1;
                    c_d.state  = ST_PTR_ACK;
                end
            end
            ST_PTR_ACK, ST_WDATA_ACK: begin
                if (scl_fall) begin
                    c_d.sda_oe = 1'b0;
                    c_d.state  = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (scl_fall && c_q.bitcnt == BITS_IN) begin
                    c_d.bitcnt = '0;
                    c_d.we     = 1'b1;
                    c_d.waddr  = c_q.ptr;
                    c_d.wdata  = c_q.shreg;
                    if (c_q.inc) c_d.ptr = c_q.ptr + 1'b1;
                    c_d.sda_oe = 1'b1;
                    c_d.state  = ST_WDATA_ACK;
                end
            end
            ST_RDATA: begin
                if (scl_fall) begin
                    if (c_q.bitcnt == LAST_OUT) begin
                        c_d.bitcnt = '0;
                        c_d.sda_oe = 1'b0;
                        if (c_q.inc) c_d.ptr = c_q.ptr + 1'b1;
                        c_d.state  = ST_RACK;
                    end else begin
                        c_d.shreg  = {c_q.shreg[BYTE_W-2:0], 1'b0};
                        c_d.sda_oe = ~c_q.shreg[BYTE_W-2];
                        c_d.bitcnt = c_q.bitcnt + 1'b1;
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) c_d.mnak = sda_s;
                if (scl_fall) begin
                    if (!c_q.mnak) begin
                        c_d.shreg  = rd_byte;
                        c_d.sda_oe = ~rd_byte[BYTE_W-1];
                        c_d.state  = ST_RDATA;
                        if (STRETCH_CYC > 0) begin
                            c_d.scnt   = SCW'(STRETCH_CYC);
                            c_d.scl_oe = 1'b1;
                        end
                    end else begin
                        c_d.sda_oe = 1'b0;
                        c_d.state  = ST_RWAIT;
                    end
                end
            end
            default: ;
        endcase

        // bus conditions override everything
        if (start_ev || stop_ev) begin
            c_d.state  = start_ev ? ST_ADDR : ST_IDLE;
            c_d.bitcnt = '0;
            c_d.sda_oe = 1'b0;
            c_d.scl_oe = 1'b0;
            c_d.scnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe    = c_q.sda_oe;
    assign scl_oe    = c_q.scl_oe;
    assign ptr       = c_q.ptr;
    assign auto_inc  = c_q.inc;
    assign bus_we    = c_q.we;
    assign bus_waddr = c_q.waddr;
    assign bus_wdata = c_q.wdata;
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         STRETCH_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    input  logic [6:0] usr_addr_i,
    input  logic       usr_we_i,
    input  logic [7:0] usr_wdata_i,
    output logic [7:0] usr_rdata_o
);
    import i2c_rf_pkg::*;

    localparam int AW = 7;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [AW-1:0]     ptr, bus_waddr;
    logic              auto_inc, bus_we;
    logic [BYTE_W-1:0] bus_wdata, rd_byte;

    i2c_rf_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_rf_ctrl #(
        .DEV_ADDR    (DEV_ADDR),
        .AW          (AW),
        .STRETCH_CYC (STRETCH_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe_o),
        .scl_oe    (scl_oe_o),
        .ptr       (ptr),
        .auto_inc  (auto_inc),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata)
    );

    i2c_rf_store #(
        .AW (AW),
        .DW (BYTE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (ptr),
        .bus_rdata (rd_byte),
        .usr_addr  (usr_addr_i),
        .usr_we    (usr_we_i),
        .usr_wdata (usr_wdata_i),
        .usr_rdata (usr_rdata_o)
    );

    logic unused_scl_s;
    assign unused_scl_s = scl_s;
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       stop_ev,
    input logic       bus_we,
    input logic       inc,
    input logic [6:0] ptr
);
    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe)); // R4

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe && !scl_oe)); // R9

    AST_STRETCH_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_i); // R8

    AST_WRITE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !scl_i); // R5

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_we) && inc) |-> (ptr == $past(ptr) + 7'd1)); // R7

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_we) && !inc) |-> (ptr == $past(ptr))); // R7
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe_o),
    .scl_oe  (scl_oe_o),
    .stop_ev (stop_ev),
    .bus_we  (bus_we),
    .inc     (auto_inc),
    .ptr     (ptr)
);

// File: tb/i2c_regfile_slave_tb.sv
`timescale 1ns/1ps
module i2c_regfile_slave_tb;
    localparam logic [6:0] DEV  = 7'h2A;
    localparam int         STR  = 16;
    localparam int         HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe;
    logic [6:0] usr_addr = '0;
    logic       usr_we = 1'b0;
    logic [7:0] usr_wdata = '0;
    logic [7:0] usr_rdata;
    wire scl = scl_m & ~scl_oe;
    wire sda = sda_m & ~sda_oe;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    i2c_regfile_slave #(.DEV_ADDR(DEV), .STRETCH_CYC(STR)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .usr_addr_i(usr_addr), .usr_we_i(usr_we),
        .usr_wdata_i(usr_wdata), .usr_rdata_o(usr_rdata));

    function automatic logic [7:0] pat_a(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wait_scl(output int w);
        w = 0;
        @(negedge clk);
        while (!scl) begin w++; @(negedge clk); end
    endtask

    task automatic wbit(input logic b, output int w);
        sda_m = b; hp(); scl_m = 1'b1; wait_scl(w); hp(); scl_m = 1'b0;
    endtask

    task automatic rbit(output logic first, output logic last, output int w);
        sda_m = 1'b1; hp(); scl_m = 1'b1; wait_scl(w);
        first = sda; hp(); last = sda; scl_m = 1'b0;
    endtask

    task automatic bus_start();
        int w;
        sda_m = 1'b1; hp(); scl_m = 1'b1; wait_scl(w); hp();
        sda_m = 1'b0; hp(); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        int w;
        sda_m = 1'b0; hp(); scl_m = 1'b1; wait_scl(w); hp();
        sda_m = 1'b1; hp();
    endtask

    // returns ack levels at start/end of the 9th high phase; any stretch seen
    task automatic send_byte(input logic [7:0] b, output logic a0, output logic a1,
                             output int stretch);
        int w;
        stretch = 0;
        for (int i = 7; i >= 0; i--) begin wbit(b[i], w); stretch += w; end
        rbit(a0, a1, w); stretch += w;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b,
                             output int w_first, output int w_rest);
        logic f, l;
        int w;
        w_rest = 0;
        for (int i = 7; i >= 0; i--) begin
            rbit(f, l, w);
            b[i] = f;
            if (i == 7) w_first = w; else w_rest += w;
        end
        wbit(mack, w);
        w_rest += w;
    endtask

    task automatic addr_ptr(input logic [7:0] pb, input string tag);
        logic a0, a1;
        int s;
        bus_start();
        send_byte({DEV, 1'b0}, a0, a1, s);
        chk(a0 == 0 && a1 == 0, {tag, " R2/R4 addr ack"}, {a0, a1}, 0);
        send_byte(pb, a0, a1, s);
        chk(a0 == 0 && a1 == 0 && s == 0, {tag, " R3/R4 ptr ack"}, {a0, a1}, 0);
    endtask

    task automatic usr_read(input int a, output logic [7:0] d);
        @(negedge clk); usr_addr = 7'(a); #1; d = usr_rdata;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, exp6;
        logic a0, a1;
        int s, wf, wr, nbad;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk(sda_oe == 0 && scl_oe == 0, "R1 enables after reset", {sda_oe, scl_oe}, 0);
        nbad = 0;
        for (int r = 0; r < 128; r++) begin usr_read(r, d); if (d != 0) nbad++; end
        chk(nbad == 0, "R1 registers zero", nbad, 0);

        // R5/R7: 128-byte auto-increment write from index 120 (wraps)
        addr_ptr(8'h80 | 8'd120, "wr-burst");
        nbad = 0;
        for (int k = 0; k < 128; k++) begin
            send_byte(pat_a(k), a0, a1, s);
            if (a0 || a1 || s != 0) nbad++;
        end
        chk(nbad == 0, "R4/R8 data acks held, no stretch on write", nbad, 0);
        bus_stop();
        chk(sda_oe == 0 && scl_oe == 0, "R9 released after stop", {sda_oe, scl_oe}, 0);
        for (int r = 0; r < 128; r++) begin
            usr_read(r, d);
            chk(d == pat_a((r - 120) & 127), "R5/R7 burst write value", d, pat_a((r - 120) & 127));
        end

        // R6/R7/R8: 128-byte read from index 100 (wraps), stretch per byte
        addr_ptr(8'h80 | 8'd100, "rd-burst");
        bus_start();
        send_byte({DEV, 1'b1}, a0, a1, s);
        chk(a0 == 0 && a1 == 0, "R2 read addr ack", {a0, a1}, 0);
        for (int k = 0; k < 128; k++) begin
            recv_byte(k == 127, d, wf, wr);
            chk(d == pat_a((100 + k - 120) & 127), "R6/R7 burst read value",
                d, pat_a((100 + k - 120) & 127));
            chk(wf > 0 && wr == 0, "R8 stretch only before byte", wf, 1);
        end
        // R9: after NAK the slave leaves SDA released
        recv_byte(1'b1, d, wf, wr);
        chk(d == 8'hFF && wf == 0, "R9 released after master nak", d, 8'hFF);
        bus_stop();

        // R7: fixed pointer write then read
        usr_read(6, exp6);
        addr_ptr(8'h05, "fixed-wr");
        send_byte(8'h11, a0, a1, s);
        send_byte(8'h22, a0, a1, s);
        send_byte(8'h33, a0, a1, s);
        bus_stop();
        usr_read(5, d);
        chk(d == 8'h33, "R7 fixed pointer last byte wins", d, 8'h33);
        usr_read(6, d);
        chk(d == exp6, "R7 fixed pointer neighbour untouched", d, exp6);
        addr_ptr(8'h05, "fixed-rd");
        bus_start();
        send_byte({DEV, 1'b1}, a0, a1, s);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k == 2, d, wf, wr);
            chk(d == 8'h33, "R7 fixed pointer read repeats", d, 8'h33);
        end
        bus_stop();

        // R2: every other address is not acknowledged
        nbad = 0;
        for (int a = 0; a < 128; a++) begin
            if (7'(a) == DEV) continue;
            bus_start();
            send_byte({7'(a), 1'b0}, a0, a1, s);
            if (!(a0 && a1)) nbad++;
            if (a < 3) begin
                send_byte(8'h07, a0, a1, s);
                send_byte(8'hEE, a0, a1, s);
                if (!(a0 && a1)) nbad++;
            end
            bus_stop();
        end
        chk(nbad == 0, "R2 foreign addresses not acked", nbad, 0);
        usr_read(7, d);
        chk(d == pat_a((7 - 120) & 127), "R2 foreign write ignored", d, pat_a((7 - 120) & 127));

        // R10: user write visible to bus
        @(negedge clk); usr_addr = 7'h40; usr_wdata = 8'hA5; usr_we = 1'b1;
        @(negedge clk); usr_we = 1'b0;
        usr_read(8'h40, d);
        chk(d == 8'hA5, "R10 user write readback", d, 8'hA5);
        addr_ptr(8'h40, "usr");
        bus_start();
        send_byte({DEV, 1'b1}, a0, a1, s);
        recv_byte(1'b1, d, wf, wr);
        chk(d == 8'hA5, "R10 user write seen on bus", d, 8'hA5);
        bus_stop();

        // R9: STOP in the middle of a data byte aborts it
        addr_ptr(8'h80 | 8'h10, "abort");
        for (int i = 0; i < 4; i++) wbit(1'b0, s);
        bus_stop();
        usr_read(8'h10, d);
        chk(d == pat_a((16 - 120) & 127), "R9 partial byte discarded", d, pat_a((16 - 120) & 127));
        bus_start();
        send_byte({DEV, 1'b0}, a0, a1, s);
        chk(a0 == 0 && a1 == 0, "R9 fresh address after abort", {a0, a1}, 0);
        bus_stop();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule